// File: doc/BRIEF.md
# Dual-Policy Priority Interrupt Controller

This block gathers interrupt requests from four sources and offers exactly one of them at a time to a processor. The sources are a hardware-failure alarm, an I/O-done or I/O-error signal, a periodic timer and program exceptions such as overflow or division by zero. A request counts when its input line rises. The block holds it as pending until the processor accepts it. The source then becomes the in-service level until the processor strobes end-of-service.

A mode input picks one of two policies, and it can be changed at any time. In sequential mode, nothing is offered while any level is in service. Pending sources are then offered strictly in arrival order. In nested mode, a pending source whose priority is above the current in-service level is offered at once and can preempt it. Sources with lower priority wait. Accepted levels sit on an in-service stack, so each end-of-service returns the block to the level that was preempted.

The stack is controlled by a four-state machine that follows the number of live levels: `SV_IDLE` (none), `SV_SINGLE` (one), `SV_NESTED` (two up to one below the source count) and `SV_FULL` (every source in service). The transitions are push (accept), pop (end-of-service) and swap (accept and end-of-service in the same cycle). Push moves `SV_IDLE` to `SV_SINGLE`, `SV_SINGLE` to `SV_NESTED`, and `SV_NESTED` to `SV_FULL` when the last free slot fills. Pop moves `SV_FULL` back to `SV_NESTED`, `SV_NESTED` to `SV_SINGLE` when two levels were live, and `SV_SINGLE` to `SV_IDLE`. Swap leaves the state unchanged.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, irq_o and lvl_valid_o are low, and vec_o and lvl_o are 0.
- R2: A low-to-high change on req_i[s] makes source s pending from the next clock edge. A line held high raises no further request. A rise on a source that is already pending or in service at that edge is dropped.
- R3: Source IDs are 3 = hardware failure, 2 = I/O, 1 = timer and 0 = program. A larger ID has the higher priority.
- R4: With nest_mode_i low, irq_o is high only while no level is in service and some source is pending. vec_o then gives the earliest-arrived pending source.
- R5: Sources that rise in the same cycle are queued from the highest ID down to the lowest.
- R6: With nest_mode_i high, irq_o is high when the highest pending ID is above lvl_o, or when nothing is in service. vec_o gives that ID.
- R7: With nest_mode_i high, a pending source whose ID is not above lvl_o is not offered. The current level stays in service.
- R8: An ack_i while irq_o is high removes vec_o from pending. From the next cycle, that source is lvl_o with lvl_valid_o high. An ack_i while irq_o is low has no effect.
- R9: An eos_i ends the top level. In the next cycle, lvl_o shows the level it had preempted, or lvl_valid_o is low, and irq_o is re-evaluated against that level. An eos_i with nothing in service has no effect.
- R10: An accepted ack_i together with eos_i replaces the top level with the accepted source. The depth does not change.
- R11: vec_o is 0 whenever irq_o is low, and lvl_o is 0 whenever lvl_valid_o is low.
- R12: In sequential mode, irq_o stays low while any level is in service. This includes levels stacked before a switch out of nested mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Request lines, one per source, rising-edge sensitive |
| nest_mode_i | input | 1 | 1 = nested priority preemption, 0 = sequential |
| ack_i | input | 1 | Processor accepts the offered source |
| eos_i | input | 1 | End of service for the current top level |
| irq_o | output | 1 | Interrupt offered to the processor |
| vec_o | output | ID_W | ID of the offered source |
| lvl_valid_o | output | 1 | Some level is in service |
| lvl_o | output | ID_W | ID of the current in-service level |

## Verification
Staggered single arrivals in sequential mode separate arrival-order service from priority-order service. Simultaneous arrivals test the tie-break order of the queue. Nested runs climb all four levels and then unwind them one at a time, which shows that each pop returns to the preempted level. A lower-priority arrival during a high-level service has to stay silent. Other directed cases cover the corners: re-raises of in-service sources, stray acks and end-of-service strobes, a same-cycle accept with end-of-service, and a mode switch with two levels stacked. A long random run, with mode changes, is compared every cycle against a queue-based model.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    // Service-stack occupancy states
    typedef enum logic [1:0] {
        SV_IDLE   = 2'd0,
        SV_SINGLE = 2'd1,
        SV_NESTED = 2'd2,
        SV_FULL   = 2'd3
    } svc_state_e;

    // Per-cycle stack operation
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } stk_op_e;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int NUM_SRC = 4,
    parameter int ID_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] inserv_i,
    input  logic               take_i,
    input  logic [ID_W-1:0]    take_id_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] fresh_o
);

    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] take_mask;

    always_comb begin
        take_mask = take_i ? (NUM_SRC'(1) << take_id_i) : '0;
        // R2: only a new rise from a source neither pending nor in service
        fresh_o   = req_i & ~req_q & ~pend_q & ~inserv_i;
        pend_o    = pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_i;
            pend_q <= (pend_q & ~take_mask) | fresh_o;
        end
    end

endmodule

// File: rtl/irq_arrival_queue.sv
module irq_arrival_queue #(
    parameter int NUM_SRC = 4,
    parameter int ID_W    = 2,
    parameter int CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rm_i,
    input  logic [ID_W-1:0]    rm_id_i,
    input  logic [NUM_SRC-1:0] add_mask_i,
    output logic [ID_W-1:0]    head_o,
    output logic [CNT_W-1:0]   cnt_o
);

    logic [ID_W-1:0]  slot_q [NUM_SRC];
    logic [ID_W-1:0]  slot_d [NUM_SRC];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Compact out the removed entry, then append arrivals high ID first (R5)
    always_comb begin
        slot_d = slot_q;
        cnt_d  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if ((CNT_W'(i) < cnt_q) && !(rm_i && (slot_q[i] == rm_id_i))) begin
                slot_d[cnt_d[ID_W-1:0]] = slot_q[i];
                cnt_d = cnt_d + 1'b1;
            end
        end
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (add_mask_i[s] && (cnt_d < CNT_W'(NUM_SRC))) begin
                slot_d[cnt_d[ID_W-1:0]] = ID_W'(s);
                cnt_d = cnt_d + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < NUM_SRC; i++) begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    always_comb begin
        head_o = slot_q[0];
        cnt_o  = cnt_q;
    end

endmodule

// File: rtl/irq_service_stack.sv
module irq_service_stack
    import irq_nest_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int ID_W    = 2,
    parameter int CNT_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [ID_W-1:0]    id_i,
    output logic               top_valid_o,
    output logic [ID_W-1:0]    top_id_o,
    output logic [NUM_SRC-1:0] inserv_o,
    output logic [CNT_W-1:0]   depth_o
);

    svc_state_e       state_q, state_d;
    stk_op_e          op;
    logic [CNT_W-1:0] depth_q, depth_d;
    logic [CNT_W-1:0] depth_m1;
    logic [ID_W-1:0]  stk_q [NUM_SRC];

    always_comb begin
        unique case ({push_i, pop_i})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_HOLD;
        endcase
        depth_m1 = depth_q - 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        depth_d = depth_q;
        if (op == OP_PUSH) begin
            depth_d = depth_q + 1'b1;
        end else if (op == OP_POP) begin
            depth_d = depth_q - 1'b1;
        end
        unique case (state_q)
            SV_IDLE: begin
                if (op == OP_PUSH) begin
                    state_d = SV_SINGLE;
                end
            end
            SV_SINGLE: begin
                if (op == OP_PUSH) begin
                    state_d = (NUM_SRC == 2) ? SV_FULL : SV_NESTED;
                end else if (op == OP_POP) begin
                    state_d = SV_IDLE;
                end
            end
            SV_NESTED: begin
                if (op == OP_PUSH) begin
                    state_d = (depth_q == CNT_W'(NUM_SRC - 1)) ? SV_FULL : SV_NESTED;
                end else if (op == OP_POP) begin
                    state_d = (depth_q == CNT_W'(2)) ? SV_SINGLE : SV_NESTED;
                end
            end
            SV_FULL: begin
                if (op == OP_POP) begin
                    state_d = (NUM_SRC == 2) ? SV_SINGLE : SV_NESTED;
                end
            end
            default: state_d = SV_IDLE;
        endcase
    end

    // State register and stack storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SV_IDLE;
            depth_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                stk_q[i] <= '0;
            end
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
            if (op == OP_PUSH) begin
                stk_q[depth_q[ID_W-1:0]] <= id_i;
            end else if (op == OP_SWAP) begin
                stk_q[depth_m1[ID_W-1:0]] <= id_i;
            end
        end
    end

    // Outputs
    always_comb begin
        top_valid_o = (state_q != SV_IDLE);
        top_id_o    = top_valid_o ? stk_q[depth_m1[ID_W-1:0]] : '0;
        depth_o     = depth_q;
        inserv_o    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (CNT_W'(i) < depth_q) begin
                inserv_o[stk_q[i]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_present.sv
module irq_present #(
    parameter int NUM_SRC = 4,
    parameter int ID_W    = 2,
    parameter int CNT_W   = 3
) (
    input  logic               nest_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [ID_W-1:0]    head_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               top_valid_i,
    input  logic [ID_W-1:0]    top_id_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    vec_o
);

    logic [ID_W-1:0] best;
    logic            seq_go;
    logic            nest_go;

    always_comb begin
        best = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (pend_i[s]) begin
                best = ID_W'(s);
            end
        end
        seq_go  = !top_valid_i && (cnt_i != '0);
        nest_go = (pend_i != '0) && (!top_valid_i || (best > top_id_i));
        irq_o   = nest_i ? nest_go : seq_go;
        if (!irq_o) begin
            vec_o = '0;
        end else if (nest_i) begin
            vec_o = best;
        end else begin
            vec_o = head_i;
        end
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
    parameter int NUM_SRC = 4,
    localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W  = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               nest_mode_i,
    input  logic               ack_i,
    input  logic               eos_i,
    output logic               irq_o,
    output logic [ID_W-1:0]    vec_o,
    output logic               lvl_valid_o,
    output logic [ID_W-1:0]    lvl_o
);

    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] fresh_w;
    logic [NUM_SRC-1:0] inserv_w;
    logic [ID_W-1:0]    q_head;
    logic [CNT_W-1:0]   q_cnt;
    logic [CNT_W-1:0]   stk_depth;
    logic               top_valid;
    logic [ID_W-1:0]    top_id;
    logic               irq_w;
    logic [ID_W-1:0]    vec_w;
    logic               take;
    logic               pop;

    always_comb begin
        take = irq_w && ack_i;
        pop  = eos_i && top_valid;
    end

    irq_req_capture #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .inserv_i  (inserv_w),
        .take_i    (take),
        .take_id_i (vec_w),
        .pend_o    (pend_w),
        .fresh_o   (fresh_w)
    );

    irq_arrival_queue #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .rm_i       (take),
        .rm_id_i    (vec_w),
        .add_mask_i (fresh_w),
        .head_o     (q_head),
        .cnt_o      (q_cnt)
    );

    irq_service_stack #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (take),
        .pop_i       (pop),
        .id_i        (vec_w),
        .top_valid_o (top_valid),
        .top_id_o    (top_id),
        .inserv_o    (inserv_w),
        .depth_o     (stk_depth)
    );

    irq_present #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) u_pres (
        .nest_i      (nest_mode_i),
        .pend_i      (pend_w),
        .head_i      (q_head),
        .cnt_i       (q_cnt),
        .top_valid_i (top_valid),
        .top_id_i    (top_id),
        .irq_o       (irq_w),
        .vec_o       (vec_w)
    );

    always_comb begin
        irq_o       = irq_w;
        vec_o       = vec_w;
        lvl_valid_o = top_valid;
        lvl_o       = top_id;
    end

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int NUM_SRC = 4,
    parameter int ID_W    = 2,
    parameter int CNT_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               nest_mode_i,
    input logic               ack_i,
    input logic               eos_i,
    input logic               irq_o,
    input logic [ID_W-1:0]    vec_o,
    input logic               lvl_valid_o,
    input logic [ID_W-1:0]    lvl_o,
    input logic [NUM_SRC-1:0] pend,
    input logic [CNT_W-1:0]   qcnt,
    input logic [NUM_SRC-1:0] inserv,
    input logic [CNT_W-1:0]   depth
);

    p_take_lvl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> (lvl_valid_o && (lvl_o == $past(vec_o))));

    p_seq_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_mode_i && lvl_valid_o) |-> !irq_o);

    p_nest_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_mode_i && irq_o && lvl_valid_o) |-> (vec_o > lvl_o));

    p_vec_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend[vec_o]);

    p_count_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend) == int'(qcnt));

    p_disjoint_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & inserv) == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == CNT_W'(NUM_SRC)) |-> !(irq_o && ack_i && !eos_i));

    p_pop_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_i && !(irq_o && ack_i) && (depth > CNT_W'(1))) |=> lvl_valid_o);

    p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eos_i && !(irq_o && ack_i) && (depth == CNT_W'(1))) |=> !lvl_valid_o);

endmodule

bind irq_nest_ctrl irq_nest_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nest_mode_i (nest_mode_i),
    .ack_i       (ack_i),
    .eos_i       (eos_i),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .lvl_valid_o (lvl_valid_o),
    .lvl_o       (lvl_o),
    .pend        (pend_w),
    .qcnt        (q_cnt),
    .inserv      (inserv_w),
    .depth       (stk_depth)
);

// File: tb/sim_irq_nest_ctrl.sv
`timescale 1ns/1ps
module sim_irq_nest_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_r = '0;
    logic       nest_r = 1'b0;
    logic       ack_r = 1'b0;
    logic       eos_r = 1'b0;
    logic       irq_o;
    logic [1:0] vec_o;
    logic       lvl_valid_o;
    logic [1:0] lvl_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_nest_ctrl #(.NUM_SRC(4)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_r),
        .nest_mode_i (nest_r),
        .ack_i       (ack_r),
        .eos_i       (eos_r),
        .irq_o       (irq_o),
        .vec_o       (vec_o),
        .lvl_valid_o (lvl_valid_o),
        .lvl_o       (lvl_o)
    );

    // ---------------- behavioural reference model ----------------
    int         m_fifo[$];
    int         m_stk[$];
    logic [3:0] m_pend = '0;
    logic [3:0] m_reqq = '0;

    function automatic void model_out(output bit irq, output int vec);
        int hp;
        irq = 1'b0;
        vec = 0;
        if (!nest_r) begin
            if (m_stk.size() == 0 && m_fifo.size() > 0) begin
                irq = 1'b1;
                vec = m_fifo[0];
            end
        end else begin
            hp = -1;
            for (int s = 0; s < 4; s++) if (m_pend[s]) hp = s;
            if (hp >= 0 && (m_stk.size() == 0 || hp > m_stk[m_stk.size()-1])) begin
                irq = 1'b1;
                vec = hp;
            end
        end
    endfunction

    always @(posedge clk) begin
        bit         m_irq;
        int         m_vec;
        logic [3:0] insv;
        logic [3:0] fresh;
        bit         tk;
        if (!rst_n) begin
            m_fifo.delete();
            m_stk.delete();
            m_pend = '0;
            m_reqq = '0;
        end else begin
            model_out(m_irq, m_vec);
            insv = '0;
            foreach (m_stk[i]) insv[m_stk[i]] = 1'b1;
            fresh = req_r & ~m_reqq & ~m_pend & ~insv;
            tk = m_irq && ack_r;
            if (tk) begin
                for (int i = 0; i < m_fifo.size(); i++) begin
                    if (m_fifo[i] == m_vec) begin
                        m_fifo.delete(i);
                        break;
                    end
                end
                m_pend[m_vec] = 1'b0;
            end
            if (tk && eos_r && m_stk.size() > 0) m_stk[m_stk.size()-1] = m_vec;
            else if (tk) m_stk.push_back(m_vec);
            else if (eos_r && m_stk.size() > 0) void'(m_stk.pop_back());
            for (int s = 3; s >= 0; s--) begin
                if (fresh[s]) begin
                    m_fifo.push_back(s);
                    m_pend[s] = 1'b1;
                end
            end
            m_reqq = req_r;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        bit e_irq;
        int e_vec;
        int e_lvl;
        bit e_lv;
        if (cmp_en && !done) begin
            model_out(e_irq, e_vec);
            e_lv  = (m_stk.size() > 0);
            e_lvl = e_lv ? m_stk[m_stk.size()-1] : 0;
            checks++;
            if (irq_o !== e_irq || int'(vec_o) != e_vec) begin
                fails++;
                $display("FAIL %s cycle %0d: irq/vec act %0d/%0d exp %0d/%0d",
                         nest_r ? "R6" : "R4", cyc, irq_o, vec_o, e_irq, e_vec);
            end
            checks++;
            if (lvl_valid_o !== e_lv || int'(lvl_o) != e_lvl) begin
                fails++;
                $display("FAIL R8 cycle %0d: lvl_valid/lvl act %0d/%0d exp %0d/%0d",
                         cyc, lvl_valid_o, lvl_o, e_lv, e_lvl);
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: act cycle %0d exp completion", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- directed helpers ----------------
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic expect_out(bit e_irq, int e_vec, bit e_lv, int e_lvl, string tag);
        checks++;
        if (irq_o !== e_irq || int'(vec_o) != e_vec || lvl_valid_o !== e_lv || int'(lvl_o) != e_lvl) begin
            fails++;
            $display("FAIL %s: irq/vec/lv/lvl act %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
                     tag, irq_o, vec_o, lvl_valid_o, lvl_o, e_irq, e_vec, e_lv, e_lvl);
        end
    endtask

    task automatic do_ack();
        ack_r = 1'b1; tick(); ack_r = 1'b0;
    endtask

    task automatic do_eos();
        eos_r = 1'b1; tick(); eos_r = 1'b0;
    endtask

    task automatic set_req(logic [3:0] v);
        req_r = v; tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        expect_out(0, 0, 0, 0, "R1");
        rst_n = 1'b1;
        tick();
        cmp_en = 1'b1;
        expect_out(0, 0, 0, 0, "R1");

        // Sequential: staggered arrivals served in arrival order (R4)
        nest_r = 1'b0;
        set_req(4'b0010); expect_out(1, 1, 0, 0, "R4");
        set_req(4'b0110); expect_out(1, 1, 0, 0, "R4");
        set_req(4'b0111); expect_out(1, 1, 0, 0, "R4");
        do_ack();         expect_out(0, 0, 1, 1, "R8");
        do_eos();         expect_out(1, 2, 0, 0, "R4");
        do_ack();         expect_out(0, 0, 1, 2, "R12");
        do_eos();         expect_out(1, 0, 0, 0, "R4");
        do_ack(); do_eos(); expect_out(0, 0, 0, 0, "R11");
        set_req(4'b0000);

        // Simultaneous arrivals queued high ID first (R5)
        set_req(4'b1101); expect_out(1, 3, 0, 0, "R5");
        do_ack();         expect_out(0, 0, 1, 3, "R3");
        do_eos();         expect_out(1, 2, 0, 0, "R5");
        do_ack(); do_eos(); expect_out(1, 0, 0, 0, "R5");
        do_ack(); do_eos();
        // Held-high lines raise nothing more (R2)
        tick(); tick();   expect_out(0, 0, 0, 0, "R2");
        // Stray ack and stray eos are ignored (R8, R9)
        do_ack();         expect_out(0, 0, 0, 0, "R8");
        do_eos();         expect_out(0, 0, 0, 0, "R9");
        set_req(4'b0000);

        // Nested: climb all four levels, then unwind (R6, R9)
        nest_r = 1'b1;
        set_req(4'b0001); expect_out(1, 0, 0, 0, "R6");
        do_ack();
        set_req(4'b0011); expect_out(1, 1, 1, 0, "R6");
        do_ack();         expect_out(0, 0, 1, 1, "R8");
        set_req(4'b0010);
        set_req(4'b0011); expect_out(0, 0, 1, 1, "R2");
        set_req(4'b0111); expect_out(1, 2, 1, 1, "R3");
        do_ack();
        set_req(4'b1111); expect_out(1, 3, 1, 2, "R6");
        do_ack();         expect_out(0, 0, 1, 3, "R6");
        do_eos();         expect_out(0, 0, 1, 2, "R9");
        do_eos();         expect_out(0, 0, 1, 1, "R9");
        do_eos();         expect_out(0, 0, 1, 0, "R9");
        do_eos();         expect_out(0, 0, 0, 0, "R9");
        set_req(4'b0000);

        // Nested: lower arrival waits, offered after eos (R7, R9)
        set_req(4'b1000); do_ack();
        set_req(4'b1010); expect_out(0, 0, 1, 3, "R7");
        do_eos();         expect_out(1, 1, 0, 0, "R9");
        do_ack(); do_eos();
        set_req(4'b0000);

        // Accept and end-of-service in one cycle swaps the top (R10)
        set_req(4'b0001); do_ack();
        set_req(4'b0101); expect_out(1, 2, 1, 0, "R6");
        ack_r = 1'b1; eos_r = 1'b1; tick(); ack_r = 1'b0; eos_r = 1'b0;
        expect_out(0, 0, 1, 2, "R10");
        do_eos();         expect_out(0, 0, 0, 0, "R10");
        set_req(4'b0000);

        // Switch to sequential with two levels stacked (R12)
        set_req(4'b0001); do_ack();
        set_req(4'b0011); do_ack();
        nest_r = 1'b0;
        set_req(4'b0111); expect_out(0, 0, 1, 1, "R12");
        do_eos();         expect_out(0, 0, 1, 0, "R12");
        do_eos();         expect_out(1, 2, 0, 0, "R12");
        do_ack(); do_eos();
        set_req(4'b0000);

        // Random traffic, model compared every cycle (R4, R6, R8)
        for (int n = 0; n < 4000; n++) begin
            for (int s = 0; s < 4; s++) begin
                if ($urandom_range(7) == 0) req_r[s] = ~req_r[s];
            end
            if ($urandom_range(199) == 0) nest_r = ~nest_r;
            ack_r = irq_o ? ($urandom_range(2) == 0) : ($urandom_range(9) == 0);
            eos_r = lvl_valid_o ? ($urandom_range(5) == 0) : ($urandom_range(19) == 0);
            tick();
        end
        ack_r = 1'b0;
        eos_r = 1'b0;
        tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule